// File: doc/BRIEF.md
# Handshaked Single-Operation ALU Stage

This block is a small arithmetic and logic stage. A controlling unit drives it through two handshakes. On the request side, the unit drives an opcode and two operands and holds `in_valid` high. The stage answers with a single-clock `in_ready` pulse one clock later. The operands and opcode present during that pulse are the accepted operation.

On the reply side, the stage produces the result one clock after the pulse and raises `out_valid`. It holds the result and `out_valid` until the controlling unit raises `out_ready`. It then lowers `out_valid` one clock later. The result may be used only in a cycle where `out_valid` and `out_ready` are both high.

Only one operation is in flight at a time. A request that arrives while a result is waiting is stalled. It is served once the result has been taken.

Top module: `alu_hs_stage`

## Requirements
- R1: A synchronous active-high reset drives `in_ready` and `out_valid` low, including when an operation is in progress.
- R2: When the stage is idle and `in_valid` is sampled high at a clock edge, `in_ready` is high in the following cycle. It is high for exactly one cycle per accepted operation.
- R3: `out_valid` rises in the cycle right after the `in_ready` pulse. `out_data` then holds the result of the opcode applied to the operands present during the pulse. Results wrap modulo 2^W.
- R4: The opcode is 3 bits wide. 000 gives A+B, 001 gives A-B, 010 gives A AND B, 011 gives A OR B, and 100 gives A XOR B. Codes 101, 110 and 111 give zero.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R6: When `out_valid` and `out_ready` are both sampled high at an edge, `out_valid` is low in the next cycle.
- R7: While a result is pending, `in_ready` stays low even if `in_valid` is high. A request held through that time gets its `in_ready` pulse in the second cycle after `out_valid` falls.
- R8: Changes on the opcode and operand inputs after the `in_ready` cycle have no effect on `out_data` for that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request from the controlling unit |
| in_ready | output | 1 | One-cycle acceptance pulse |
| op_code | input | 3 | Operation select |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken by the controlling unit |
| out_data | output | W | Result |

## Verification
A stuck busy indication shows up as a missing `in_ready` pulse on the next request. The bench sees this within two cycles of raising `in_valid`. A pulse that lasts too long shows as `in_ready` still high in the cycle when `out_valid` rises. A result register that is not frozen shows as `out_data` moving while the stage waits for `out_ready`. The bench exposes this by changing the operand inputs during that wait. A release path that misbehaves shows as `out_valid` still high one cycle after it was taken, or as a stalled request that never gets its pulse.

// File: rtl/alu_hs_stage.sv
module alu_hs_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic [W-1:0] alu_out;

  always_comb begin
    case (op_code)
      3'b000:  alu_out = opnd_a + opnd_b;
      3'b001:  alu_out = opnd_a - opnd_b;
      3'b010:  alu_out = opnd_a & opnd_b;
      3'b011:  alu_out = opnd_a | opnd_b;
      3'b100:  alu_out = opnd_a ^ opnd_b;
      default: alu_out = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      in_ready <= in_valid & ~in_ready & ~out_valid;
      if (in_ready) begin
        out_data  <= alu_out;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/alu_hs_checker.sv
module alu_hs_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);

  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  a_r3_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_ready));

  a_r5_hold_result: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r6_release: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> !out_valid);

  a_r7_no_ready_pending: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r2_ready_needs_request: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(in_valid));

endmodule

bind alu_hs_stage alu_hs_checker #(.W(W)) u_chk (.*);

// File: tb/alu_hs_stage_bench.sv
module alu_hs_stage_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] op_code = '0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu_hs_stage #(.W(W)) u_alu_hs_stage (.*);

  localparam logic [50:0] VEC [0:7] = '{
    {3'd0, 16'h0003, 16'h0004, 16'h0007},
    {3'd0, 16'hFFFF, 16'h0002, 16'h0001},
    {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
    {3'd2, 16'hF0F0, 16'h3CFF, 16'h30F0},
    {3'd3, 16'hF000, 16'h000F, 16'hF00F},
    {3'd4, 16'hAAAA, 16'hFFFF, 16'h5555},
    {3'd5, 16'h1234, 16'h5678, 16'h0000},
    {3'd7, 16'hFFFF, 16'hFFFF, 16'h0000}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one operation. The caller is at a negedge with the stage idle.
  task automatic run_op(input logic [2:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] exp,
                        input int wait_cycles, input string tag);
    in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
    tick;
    chk(in_ready == 1'b1, {"R2 ready pulse ", tag}, in_ready, 1);
    chk(out_valid == 1'b0, {"R3 not yet valid ", tag}, out_valid, 0);
    tick;
    in_valid = 1'b0;
    chk(in_ready == 1'b0, {"R2 pulse one cycle ", tag}, in_ready, 0);
    chk(out_valid == 1'b1, {"R3 valid after pulse ", tag}, out_valid, 1);
    chk(out_data == exp, {"R4 result ", tag}, out_data, exp);
    opnd_a = ~a; opnd_b = a ^ b; op_code = op + 3'd1;
    for (int i = 0; i < wait_cycles; i++) begin
      tick;
      chk(out_valid == 1'b1, {"R5 held valid ", tag}, out_valid, 1);
      chk(out_data == exp, {"R8 held data ", tag}, out_data, exp);
    end
    out_ready = 1'b1;
    tick;
    out_ready = 1'b0;
    chk(out_valid == 1'b0, {"R6 release ", tag}, out_valid, 0);
  endtask

  initial begin
    repeat (3) tick;
    chk(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst = 1'b0;
    tick;

    for (int k = 0; k < 8; k++) begin
      run_op(VEC[k][50:48], VEC[k][47:32], VEC[k][31:16], VEC[k][15:0], k % 3,
             $sformatf("vec%0d", k));
      tick;
    end

    // R7: request held while a result is pending
    in_valid = 1'b1; op_code = 3'd0; opnd_a = 16'h0010; opnd_b = 16'h0020;
    tick;
    tick;
    chk(out_valid == 1'b1 && out_data == 16'h0030, "R7 first result", out_data, 16'h0030);
    opnd_a = 16'h0100; opnd_b = 16'h0001; op_code = 3'd1;
    for (int i = 0; i < 3; i++) begin
      tick;
      chk(in_ready == 1'b0, "R7 ready stalled", in_ready, 0);
    end
    out_ready = 1'b1;
    tick;
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R7 drop cycle", in_ready, 0);
    tick;
    chk(in_ready == 1'b1, "R7 stalled request served", in_ready, 1);
    tick;
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && out_data == 16'h00FF, "R7 second result", out_data, 16'h00FF);
    out_ready = 1'b1;
    tick;
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R6 release second", out_valid, 0);

    // out_ready while idle does nothing
    out_ready = 1'b1;
    tick;
    tick;
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R6 idle out_ready", out_valid, 0);

    // R1: reset in the middle of an operation
    in_valid = 1'b1; op_code = 3'd4; opnd_a = 16'h00FF; opnd_b = 16'h0F0F;
    tick;
    tick;
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R3 valid before reset", out_valid, 1);
    rst = 1'b1;
    tick;
    rst = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b0, "R1 mid-op reset", out_valid, 0);
    tick;
    chk(out_valid == 1'b0, "R1 stays idle", out_valid, 0);

    run_op(3'd1, 16'h0000, 16'h0001, 16'hFFFF, 2, "post-reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule